// File: doc/BRIEF.md
# Expansion Bus Card Select and Window Decoder

This block is the bus-side glue for one peripheral card on an 8-bit processor expansion bus. The bus carries the processor's own address, data and control lines without buffering, so every decision is made inside one bus cycle. Up to eight cards share one write-only select byte at $D1FF. Each card watches a single bit of that byte, chosen by a 3-bit strap, and ignores every other bit.

While its bit is set, the card takes over the 2 KiB window $D800–$DFFF. That window is where the host keeps its floating-point ROM code, and the card's own ROM answers there instead. The card raises a request that tells the host memory manager to drop its ROM from the window. It also decodes a page of card I/O registers at $D100–$D1FE. The card drives the data bus only in phase 2 of a read cycle that hits one of its decoded areas. The bus cannot read the select byte back.

Top module: `pbus_card_decode`

## Requirements
- R1: The select byte is loaded from `data_in` at a rising `clk` edge only when `phi2` is 1, `rw` is 0 (write) and `addr` equals $D1FF. A write with `phi2` at 0, a read cycle, or a write to any other address leaves it unchanged.
- R2: `card_selected` equals bit number `slot` of the select byte, for every strap value 0 to 7.
- R3: While `rst_n` is 0 the select byte is all zeros. No card is selected, `host_rom_off` is 0 and `data_oe` is 0.
- R4: `rom_cs` and `host_rom_off` are 1 exactly when the card is selected and `addr` is in $D800–$DFFF. `rom_addr` is `addr[10:0]`, so $D800 maps to offset 0 and $D819–$D81B map to offsets $19–$1B.
- R5: `io_cs` is 1 exactly when the card is selected and `addr` is in $D100–$D1FE. `io_addr` is `addr[7:0]`. The address $D1FF never raises `io_cs`.
- R6: `data_oe` is 1 only when `phi2` is 1, `rw` is 1 (read) and either `rom_cs` or `io_cs` is 1. A read of $D1FF never raises it.
- R7: `data_out` carries `rom_rdata` during a ROM-window hit and `io_rdata` during an I/O-page hit.
- R8: When a written byte has several bits set, this card follows only its own bit. Writing a byte with its bit clear deselects it even if other bits are set.
- R9: All decode outputs follow `addr`, `phi2`, `rw` and `slot` in the same cycle, with no register in the path and no wait state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| phi2 | input | 1 | Phase-2 qualifier for bus transfers |
| rw | input | 1 | 1 = read cycle, 0 = write cycle |
| addr | input | 16 | Bus address |
| data_in | input | 8 | Bus data from the processor |
| slot | input | 3 | Strap giving this card's select bit number |
| rom_rdata | input | 8 | Byte from the card ROM at `rom_addr` |
| io_rdata | input | 8 | Byte from the card I/O register at `io_addr` |
| card_selected | output | 1 | This card's select bit |
| host_rom_off | output | 1 | Request to the host to switch its ROM out of the window |
| rom_cs | output | 1 | Card ROM chip select |
| rom_addr | output | 11 | Offset into the card ROM |
| io_cs | output | 1 | Card I/O page select |
| io_addr | output | 8 | Offset into the I/O page |
| data_out | output | 8 | Byte driven onto the bus |
| data_oe | output | 1 | Bus drive enable |

## Verification
The only registered result is the select byte. It changes at the rising edge that ends a qualifying write, so the bench reads `card_selected` at the next falling edge, one cycle after the write. All decode results are combinational and are due within the same cycle. The bench changes address and control at a falling edge and samples one nanosecond later, well before the next rising edge. Reset clears the select byte at once, so that check is also taken inside the cycle in which `rst_n` falls.

// File: rtl/pbus_card_decode.sv
module pbus_card_decode #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int SLOTS  = 8,
  parameter int ROM_AW = 11,
  parameter int IO_AW  = 8,
  parameter logic [ADDR_W-1:0] SEL_ADDR = 16'hD1FF,
  parameter logic [ADDR_W-1:0] ROM_BASE = 16'hD800,
  parameter logic [ADDR_W-1:0] IO_BASE  = 16'hD100,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phi2,
  input  logic              rw,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data_in,
  input  logic [SLOT_W-1:0] slot,
  input  logic [DATA_W-1:0] rom_rdata,
  input  logic [DATA_W-1:0] io_rdata,
  output logic              card_selected,
  output logic              host_rom_off,
  output logic              rom_cs,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              io_cs,
  output logic [IO_AW-1:0]  io_addr,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe
);
  localparam int ROM_TAG_W = ADDR_W - ROM_AW;
  localparam int IO_TAG_W  = ADDR_W - IO_AW;
  localparam logic [ROM_TAG_W-1:0] ROM_TAG = ROM_BASE[ADDR_W-1:ROM_AW];
  localparam logic [IO_TAG_W-1:0]  IO_TAG  = IO_BASE[ADDR_W-1:IO_AW];

  logic [SLOTS-1:0] sel_q;
  logic             sel_wr, in_rom, in_io;

  assign sel_wr = phi2 && !rw && (addr == SEL_ADDR);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      sel_q <= '0;
    else if (sel_wr) sel_q <= data_in[SLOTS-1:0];

  assign card_selected = sel_q[slot];
  assign in_rom   = addr[ADDR_W-1:ROM_AW] == ROM_TAG;
  assign in_io    = (addr[ADDR_W-1:IO_AW] == IO_TAG) && (addr != SEL_ADDR);
  assign rom_cs   = card_selected && in_rom;
  assign io_cs    = card_selected && in_io;
  assign host_rom_off = rom_cs;
  assign rom_addr = addr[ROM_AW-1:0];
  assign io_addr  = addr[IO_AW-1:0];
  assign data_oe  = phi2 && rw && (rom_cs || io_cs);
  assign data_out = rom_cs ? rom_rdata : (io_cs ? io_rdata : '0);
endmodule

module pbus_card_decode_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        phi2,
  input logic        rw,
  input logic [15:0] addr,
  input logic [7:0]  data_in,
  input logic [2:0]  slot,
  input logic        card_selected,
  input logic        host_rom_off,
  input logic        rom_cs,
  input logic        io_cs,
  input logic        data_oe
);
  assert_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (phi2 && !rw && addr == 16'hD1FF && $stable(slot)) |=> card_selected == $past(data_in[slot]));
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(phi2 && !rw && addr == 16'hD1FF) |=> ($stable(card_selected) || !$stable(slot)));
  assert_clear_R3: assert property (@(posedge clk)
    !rst_n |-> (!card_selected && !host_rom_off && !data_oe));
  assert_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    host_rom_off |-> (card_selected && addr >= 16'hD800));
  assert_io_R5: assert property (@(posedge clk) disable iff (!rst_n)
    io_cs |-> (card_selected && addr != 16'hD1FF && !rom_cs));
  assert_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> (phi2 && rw && card_selected && addr != 16'hD1FF));
endmodule

bind pbus_card_decode pbus_card_decode_chk i_chk (
  .clk(clk), .rst_n(rst_n), .phi2(phi2), .rw(rw), .addr(addr),
  .data_in(data_in), .slot(slot), .card_selected(card_selected),
  .host_rom_off(host_rom_off), .rom_cs(rom_cs), .io_cs(io_cs),
  .data_oe(data_oe)
);

// File: tb/test_pbus_card_decode.sv
module test_pbus_card_decode;
  logic        clk = 0, rst_n = 0, phi2 = 0, rw = 1;
  logic [15:0] addr = 16'h0000;
  logic [7:0]  data_in = 0;
  logic [2:0]  slot = 3'd5;
  logic [7:0]  rom_rdata, io_rdata, data_out;
  logic [10:0] rom_addr;
  logic [7:0]  io_addr;
  logic        card_selected, host_rom_off, rom_cs, io_cs, data_oe;
  logic [7:0]  rom_m [0:2047];
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  assign rom_rdata = rom_m[rom_addr];
  assign io_rdata  = io_addr ^ 8'h5A;

  pbus_card_decode i_pbus_card_decode (
    .clk(clk), .rst_n(rst_n), .phi2(phi2), .rw(rw), .addr(addr),
    .data_in(data_in), .slot(slot), .rom_rdata(rom_rdata), .io_rdata(io_rdata),
    .card_selected(card_selected), .host_rom_off(host_rom_off), .rom_cs(rom_cs),
    .rom_addr(rom_addr), .io_cs(io_cs), .io_addr(io_addr),
    .data_out(data_out), .data_oe(data_oe)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; data_in = d; rw = 0; phi2 = 1;
    @(negedge clk); phi2 = 0; rw = 1; addr = 16'h0000; #1;
  endtask

  task automatic bus_read(input logic [15:0] a);
    @(negedge clk); addr = a; rw = 1; phi2 = 1; #1;
  endtask

  task automatic t_reset;
    chk("R3 sel at reset", card_selected, 0);
    bus_read(16'hD800);
    chk("R3 off at reset", host_rom_off, 0);
    chk("R3 oe at reset", data_oe, 0);
    @(negedge clk); rst_n = 1; phi2 = 0;
  endtask

  task automatic t_select;
    bus_write(16'hD1FF, 8'h20);
    chk("R1 load own bit", card_selected, 1);
    chk("R2 slot5 bit", card_selected, 1);
    bus_write(16'hD1FF, 8'h00);
    chk("R1 load clear", card_selected, 0);
  endtask

  task automatic t_ignored;
    bus_write(16'hD1FF, 8'h20);
    @(negedge clk); addr = 16'hD1FF; data_in = 8'h00; rw = 0; phi2 = 0;
    @(negedge clk); #1;
    chk("R1 write without phi2", card_selected, 1);
    @(negedge clk); addr = 16'hD1FF; rw = 1; phi2 = 1;
    @(negedge clk); #1;
    chk("R1 read cycle no load", card_selected, 1);
    bus_write(16'hD1FE, 8'h00);
    chk("R1 other address", card_selected, 1);
    bus_write(16'hD0FF, 8'h00);
    chk("R1 other page", card_selected, 1);
  endtask

  task automatic t_rom;
    bus_write(16'hD1FF, 8'h20);
    bus_read(16'hD800);
    chk("R4 rom_cs D800", rom_cs, 1);
    chk("R4 host_rom_off", host_rom_off, 1);
    chk("R7 data D800", data_out, rom_m[0]);
    chk("R6 oe rom", data_oe, 1);
    for (int i = 16'hD819; i <= 16'hD81B; i++) begin
      bus_read(i[15:0]);
      chk("R4 rom_addr vector", rom_addr, i[10:0]);
      chk("R7 vector byte", data_out, rom_m[i[10:0]]);
    end
    bus_read(16'hDFFF);
    chk("R4 top of window", host_rom_off, 1);
    bus_read(16'hD7FF);
    chk("R4 below window", host_rom_off, 0);
    bus_read(16'hE000);
    chk("R4 above window", rom_cs, 0);
    bus_write(16'hD1FF, 8'h00);
    bus_read(16'hD819);
    chk("R4 deselected off", host_rom_off, 0);
    chk("R6 deselected oe", data_oe, 0);
  endtask

  task automatic t_io;
    bus_write(16'hD1FF, 8'h20);
    bus_read(16'hD100);
    chk("R5 io D100", io_cs, 1);
    chk("R7 io data", data_out, 8'h00 ^ 8'h5A);
    bus_read(16'hD1FE);
    chk("R5 io D1FE", io_cs, 1);
    chk("R5 io_addr", io_addr, 8'hFE);
    bus_read(16'hD1FF);
    chk("R5 no io at D1FF", io_cs, 0);
    chk("R6 no drive at D1FF", data_oe, 0);
    @(negedge clk); addr = 16'hD140; rw = 0; phi2 = 1; #1;
    chk("R6 no drive on write", data_oe, 0);
    @(negedge clk); rw = 1; phi2 = 0; #1;
    chk("R6 no drive phi2 low", data_oe, 0);
    phi2 = 1; #1;
    chk("R9 same cycle oe", data_oe, 1);
    phi2 = 0;
  endtask

  task automatic t_multi;
    bus_write(16'hD1FF, 8'hFF);
    chk("R8 all bits set", card_selected, 1);
    bus_write(16'hD1FF, 8'hDF);
    chk("R8 own bit clear", card_selected, 0);
    bus_write(16'hD1FF, 8'h21);
    chk("R8 two bits", card_selected, 1);
  endtask

  task automatic t_slots;
    bus_write(16'hD1FF, 8'hA5);
    for (int s = 0; s < 8; s++) begin
      @(negedge clk); slot = s[2:0]; addr = 16'hD900; rw = 1; phi2 = 1; #1;
      chk("R2 strap slot", card_selected, (8'hA5 >> s) & 1);
      chk("R9 strap to window", host_rom_off, (8'hA5 >> s) & 1);
    end
    @(negedge clk); slot = 3'd5; phi2 = 0;
  endtask

  task automatic t_reset_mid;
    bus_write(16'hD1FF, 8'h20);
    @(negedge clk); addr = 16'hD800; phi2 = 1; rw = 1; rst_n = 0; #1;
    chk("R3 async clear", card_selected, 0);
    chk("R3 oe clear", data_oe, 0);
    @(negedge clk); rst_n = 1; phi2 = 0; #1;
    chk("R3 stays clear", card_selected, 0);
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) rom_m[i] = 8'(i * 7 + 3);
    rom_m[0] = 8'h80; rom_m[8'h19] = 8'h4C; rom_m[8'h1A] = 8'h40; rom_m[8'h1B] = 8'hD8;
    repeat (2) @(negedge clk);
    t_reset();
    t_select();
    t_ignored();
    t_rom();
    t_io();
    t_multi();
    t_slots();
    t_reset_mid();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule